// File: doc/BRIEF.md
# Colour Lookup Table with Streaming Register Port

This block holds a 256-entry colour table, each entry made of an 8-bit red, an 8-bit green and an 8-bit blue component. A host programs it over a small 32-bit register window. The host writes an entry number to an index register. It then writes the components of that entry one after another, red first, green second and blue third, to a data register. After the blue write the index moves to the next entry, so the host can stream a complete palette as a flat run of data writes that follows a single index write.

A pixel pipeline reads the table through a separate combinational port. It presents an 8-bit pixel code and receives the 24-bit colour in the same cycle. Each time a component is stored, the block sends a one-cycle notice that names the entry that changed, so a downstream consumer can drop any colour it has cached for that entry. Register reads always return zero.

Top module: `clut_dac`

## Requirements
- R1: While reset is held and after it is released, entries 0 to 254 read as 0x000000, entry 255 reads as 0xFFFFFF, the index is 0 and the next data write targets red. `upd_valid` is low.
- R2: A write to byte address 0 loads the index from bits 31:24 of the write data and makes the next data write target red. This holds even when the sequence was part way through an entry.
- R3: Successive writes to byte address 4 store bits 31:24 of the write data into the red, then the green, then the blue component of the entry selected by the index.
- R4: The blue write advances the index by one modulo 256, so 255 becomes 0, and returns the sequence to red.
- R5: `bus_rdata` is zero at all times, including during writes.
- R6: A write to byte address 8 or 12, or to any address whose bits 1:0 are not zero, changes no entry and leaves the index and the component sequence as they were.
- R7: `pix_rgb` shows the entry selected by `pix_idx` in the same cycle, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R8: In the cycle after each data write, `upd_valid` is high and `upd_idx` gives the entry that was written. `upd_valid` is low in every other cycle.
- R9: A lookup of an entry during the cycle in which one of its components is being written returns the old value until the clock edge and the new value after it.
- R10: Bits 23:0 of the write data have no effect on any register or entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte address within the 16-byte window |
| bus_wdata | input | 32 | Write data. Only bits 31:24 are used. |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel code for a lookup |
| pix_rgb | output | 24 | Colour of entry `pix_idx` as {red, green, blue} |
| upd_valid | output | 1 | One-cycle notice that an entry was changed |
| upd_idx | output | 8 | Entry that was changed, valid while `upd_valid` is high |

## Verification
A component write and a pixel lookup can target the same entry in the same clock cycle. The bench sets up this clash by pointing `pix_idx` at the entry being written and driving the data write. It samples `pix_rgb` once before the edge and expects the old colour there, then samples again after the edge and expects the new colour. In a second clash, the blue write that advances the index from 255 to 0 falls in the same cycle as the update notice for that write. The bench checks that `upd_idx` names entry 255 and not the new index, and that the next data write lands in red of entry 0.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Component currently targeted by the data register.
  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  localparam int unsigned NUM_COMP = 3;

  // Word offsets within the register window.
  localparam int unsigned IDX_WORD_OFS  = 0;
  localparam int unsigned DATA_WORD_OFS = 1;

endpackage

// File: rtl/clut_rst_sync.sv
module clut_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned BUS_AW = 4,
  parameter int unsigned BUS_DW = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [COMP_W-1:0] wr_hi_byte,
  output logic              wr_en,
  output comp_e             wr_comp,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [COMP_W-1:0] wr_byte
);

  localparam int unsigned WORD_W = BUS_AW - 2;
  localparam logic [WORD_W-1:0] IDX_WORD  = WORD_W'(IDX_WORD_OFS);
  localparam logic [WORD_W-1:0] DATA_WORD = WORD_W'(DATA_WORD_OFS);

  logic [IDX_W-1:0] idx_q, idx_d;
  comp_e            seq_q, seq_d;
  logic             aligned;
  logic [WORD_W-1:0] word;
  logic             hit_idx, hit_data;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign word     = bus_addr[BUS_AW-1:2];
  assign hit_idx  = bus_we && aligned && (word == IDX_WORD);
  assign hit_data = bus_we && aligned && (word == DATA_WORD);

  // Next-state logic
  always_comb begin
    idx_d = idx_q;
    seq_d = seq_q;
    if (hit_idx) begin
      idx_d = wr_hi_byte[IDX_W-1:0];
      seq_d = COMP_R;
    end else if (hit_data) begin
      unique case (seq_q)
        COMP_R:  seq_d = COMP_G;
        COMP_G:  seq_d = COMP_B;
        default: begin
          seq_d = COMP_R;
          idx_d = idx_q + 1'b1;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      seq_q <= COMP_R;
    end else if (hit_idx || hit_data) begin
      idx_q <= idx_d;
      seq_q <= seq_d;
    end
  end

  assign wr_en   = hit_data;
  assign wr_comp = seq_q;
  assign wr_idx  = idx_q;
  assign wr_byte = wr_hi_byte;

  // Index write restarts the component sequence (R2)
  p_seq_restart_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    hit_idx |=> (seq_q == COMP_R) && (idx_q == $past(wr_hi_byte[IDX_W-1:0])));

  // Blue write advances the index (R4)
  p_idx_advance_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit_data && seq_q == COMP_B) |=>
      (seq_q == COMP_R) && (idx_q == IDX_W'($past(idx_q) + 1'b1)));

  // Writes to other offsets leave the state alone (R6)
  p_ignore_other_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(hit_idx || hit_data) |=> $stable(idx_q) && $stable(seq_q));

  // Sequence never leaves its three legal codes (R3)
  p_seq_legal_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    seq_q != comp_e'(2'd3));

endmodule

// File: rtl/clut_table.sv
module clut_table
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         wr_en,
  input  comp_e                        wr_comp,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [COMP_W-1:0]            wr_byte,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [NUM_COMP*COMP_W-1:0]   rd_rgb
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [NUM_COMP-1:0][COMP_W-1:0] rd_comp;

  // One storage plane per colour component
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
    logic [COMP_W-1:0] mem_q [DEPTH];
    logic              plane_we;

    assign plane_we = wr_en && (wr_comp == comp_e'(c));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < DEPTH; e++) begin
          mem_q[e] <= (e == DEPTH - 1) ? {COMP_W{1'b1}} : {COMP_W{1'b0}};
        end
      end else if (plane_we) begin
        mem_q[wr_idx] <= wr_byte;
      end
    end

    assign rd_comp[c] = mem_q[rd_idx];
  end

  // Red in the top byte, blue in the bottom byte
  assign rd_rgb = {rd_comp[0], rd_comp[1], rd_comp[2]};

  // A stored red byte is visible on the read port one edge later (R3, R9)
  p_red_lands_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_comp == COMP_R) |=>
      (rd_idx != $past(wr_idx)) ||
      (rd_rgb[NUM_COMP*COMP_W-1 -: COMP_W] == $past(wr_byte)));

  // A stored blue byte is visible on the read port one edge later (R3)
  p_blue_lands_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_comp == COMP_B) |=>
      (rd_idx != $past(wr_idx)) || (rd_rgb[COMP_W-1:0] == $past(wr_byte)));

endmodule

// File: rtl/clut_dac.sv
module clut_dac
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned BUS_AW = 4,
  parameter int unsigned BUS_DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [BUS_AW-1:0]          bus_addr,
  input  logic [BUS_DW-1:0]          bus_wdata,
  output logic [BUS_DW-1:0]          bus_rdata,
  input  logic [IDX_W-1:0]           pix_idx,
  output logic [NUM_COMP*COMP_W-1:0] pix_rgb,
  output logic                       upd_valid,
  output logic [IDX_W-1:0]           upd_idx
);

  localparam int unsigned HI_LSB = BUS_DW - COMP_W;

  logic              rst_sync_n;
  logic              wr_en;
  comp_e             wr_comp;
  logic [IDX_W-1:0]  wr_idx;
  logic [COMP_W-1:0] wr_byte;
  logic [HI_LSB-1:0] unused_low_bits;

  logic              upd_valid_q, upd_valid_d;
  logic [IDX_W-1:0]  upd_idx_q, upd_idx_d;

  assign unused_low_bits = bus_wdata[HI_LSB-1:0];

  clut_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  clut_seq #(
    .IDX_W  (IDX_W),
    .COMP_W (COMP_W),
    .BUS_AW (BUS_AW),
    .BUS_DW (BUS_DW)
  ) u_seq (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wr_hi_byte (bus_wdata[BUS_DW-1:HI_LSB]),
    .wr_en      (wr_en),
    .wr_comp    (wr_comp),
    .wr_idx     (wr_idx),
    .wr_byte    (wr_byte)
  );

  clut_table #(
    .IDX_W  (IDX_W),
    .COMP_W (COMP_W)
  ) u_table (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .wr_en   (wr_en),
    .wr_comp (wr_comp),
    .wr_idx  (wr_idx),
    .wr_byte (wr_byte),
    .rd_idx  (pix_idx),
    .rd_rgb  (pix_rgb)
  );

  // Update notice: next state
  always_comb begin
    upd_valid_d = wr_en;
    upd_idx_d   = wr_en ? wr_idx : upd_idx_q;
  end

  // Update notice: registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upd_valid_q <= 1'b0;
      upd_idx_q   <= '0;
    end else begin
      upd_valid_q <= upd_valid_d;
      if (wr_en) begin
        upd_idx_q <= upd_idx_d;
      end
    end
  end

  assign upd_valid = upd_valid_q;
  assign upd_idx   = upd_idx_q;
  assign bus_rdata = '0;

  // Each data write yields exactly one notice naming its entry (R8)
  p_notice_follows_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> upd_valid && (upd_idx == $past(wr_idx)));

  p_no_spurious_notice_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> !upd_valid);

endmodule

// File: tb/clut_dac_tb.sv
module clut_dac_tb;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;
  logic        upd_valid;
  logic [7:0]  upd_idx;

  int n_total = 0;
  int n_bad   = 0;

  clut_dac u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_idx   (pix_idx),
    .pix_rgb   (pix_rgb),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector fields: addr[44:41], hi byte[40:33], lookup idx[32:25], expected rgb[24:1], spare[0]
  localparam int NV = 15;
  localparam logic [44:0] VEC [NV] = '{
    {4'h0, 8'h10, 8'h10, 24'h000000, 1'b0},  // R2 index load
    {4'h4, 8'h11, 8'h10, 24'h110000, 1'b0},  // R3 red
    {4'h4, 8'h22, 8'h10, 24'h112200, 1'b0},  // R3 green
    {4'h4, 8'h33, 8'h10, 24'h112233, 1'b0},  // R3 blue
    {4'h4, 8'h44, 8'h11, 24'h440000, 1'b0},  // R4 advanced to next entry
    {4'h0, 8'h20, 8'h11, 24'h440000, 1'b0},  // R2
    {4'h4, 8'h55, 8'h20, 24'h550000, 1'b0},  // R3
    {4'h0, 8'h20, 8'h20, 24'h550000, 1'b0},  // R2 restart mid-entry
    {4'h4, 8'h66, 8'h20, 24'h660000, 1'b0},  // R2 back on red
    {4'h8, 8'h77, 8'h20, 24'h660000, 1'b0},  // R6 offset 8
    {4'h5, 8'h88, 8'h20, 24'h660000, 1'b0},  // R6 misaligned
    {4'h4, 8'h99, 8'h20, 24'h669900, 1'b0},  // R6 sequence kept: green
    {4'hC, 8'hAA, 8'h20, 24'h669900, 1'b0},  // R6 offset 12
    {4'h4, 8'hBB, 8'h20, 24'h6699BB, 1'b0},  // R3 blue
    {4'h4, 8'hCC, 8'h21, 24'hCC0000, 1'b0}   // R4 next entry red
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the falling edge after the write edge.
  task automatic bus_wr(input logic [3:0] a, input logic [7:0] hi);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = {hi, 24'hA5C3F0};  // low bits are noise (R10)
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = 32'hFFFF_FFFF;
  endtask

  task automatic look(input string req, input logic [7:0] i, input logic [23:0] exp);
    pix_idx = i;
    #0.5;
    check(req, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  initial begin
    #(4 * 150000);
    n_total++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    int sweep_bad;
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    pix_idx   = '0;
    repeat (3) @(negedge clk);

    // R1: reset contents while reset is held
    look("R1", 8'hFF, 24'hFFFFFF);
    look("R1", 8'h00, 24'h000000);
    check("R1", {31'h0, upd_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sweep_bad = 0;
    for (int e = 0; e < 256; e++) begin
      pix_idx = e[7:0];
      #0.5;
      if (pix_rgb !== ((e == 255) ? 24'hFFFFFF : 24'h000000)) sweep_bad++;
    end
    check("R1 sweep", sweep_bad, 0);
    check("R5", bus_rdata, 32'h0);

    // R7 R3 R6 R10 via vector table
    for (int v = 0; v < NV; v++) begin
      bus_wr(VEC[v][44:41], VEC[v][40:33]);
      look("R3/R6/R7 vector", VEC[v][32:25], VEC[v][24:1]);
    end

    // R8: notice after data write, none after index write
    bus_wr(4'h0, 8'h40);
    check("R8 idle", {31'h0, upd_valid}, 32'h0);
    bus_wr(4'h4, 8'h01);
    check("R8 valid", {31'h0, upd_valid}, 32'h1);
    check("R8 idx", {24'h0, upd_idx}, 32'h40);
    @(negedge clk);
    check("R8 one cycle", {31'h0, upd_valid}, 32'h0);

    // R4: wrap from 255 to 0, notice names 255
    bus_wr(4'h0, 8'hFF);
    bus_wr(4'h4, 8'h01);
    bus_wr(4'h4, 8'h02);
    bus_wr(4'h4, 8'h03);
    check("R4 notice idx", {24'h0, upd_idx}, 32'hFF);
    look("R4 entry 255", 8'hFF, 24'h010203);
    bus_wr(4'h4, 8'h04);
    look("R4 wrap to 0", 8'h00, 24'h040000);
    check("R4 notice wrap", {24'h0, upd_idx}, 32'h00);

    // R9 and R5: same-cycle lookup of the entry being written
    bus_wr(4'h0, 8'h50);
    pix_idx = 8'h50;
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = 4'h4;
    bus_wdata = {8'h77, 24'h0};
    #0.5;
    check("R9 before edge", {8'h0, pix_rgb}, 32'h000000);
    check("R5 during write", bus_rdata, 32'h0);
    @(negedge clk);
    bus_we = 1'b0;
    #0.5;
    check("R9 after edge", {8'h0, pix_rgb}, 32'h770000);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule